// File: doc/BRIEF.md
# Bit and Error Count Accumulator with Snapshot Latch

This block gathers the two raw numbers needed for a bit-error-rate figure: how many data clocks have gone by, and how many errored bits the pattern checker has seen. Each number lives in a wide saturating accumulator. The bit accumulator advances on every valid clock whatever the checker's lock state. The error accumulator only takes in the checker's per-clock error count while the checker reports lock.

Software closes a measurement window by raising a control bit. On that rising edge, both accumulators are copied into holding registers and restarted in the same clock, so no clock or error falls between two windows. Software then reads the holding registers at leisure. They keep their values until the next rising edge of the control bit.

The bit accumulator counts clocks, not bits. With a datapath several bits wide, scaling the count is left to software.

Top module: `ber_count_latch`

## Requirements
- R1: After reset both holding registers read zero and both accumulators are empty, so a snapshot taken before any valid clock reads zero.
- R2: The bit accumulator adds exactly one for each clock with `valid` high, whether `in_sync` is high or low, and adds nothing on a clock with `valid` low.
- R3: The error accumulator adds `err_cnt` only on clocks where both `valid` and `in_sync` are high; on all other clocks it is unchanged.
- R4: On a snapshot event, `bit_hold` and `err_hold` take the accumulator values from before that clock, and both accumulators restart in that same clock edge.
- R5: Increments presented in the clock of a snapshot event are counted in the new window, not in the snapshot.
- R6: Each accumulator saturates at its all-ones value and never wraps; a snapshot of a saturated accumulator reads all ones.
- R7: A snapshot event is caused only by a 0-to-1 change of `latch_ctl` between consecutive clocks. Holding it high, or lowering it, causes no further event.
- R8: Between snapshot events the holding registers keep their values unchanged.
- R9: An `err_cnt` value above ERR_MAX (default 8) is treated as ERR_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Data clock qualifier |
| err_cnt | input | ERR_W (4) | Number of errored bits this clock, from the pattern checker |
| in_sync | input | 1 | Checker lock flag; enables error accumulation |
| latch_ctl | input | 1 | Snapshot control; a rising edge latches and clears |
| bit_hold | output | CNT_W (48) | Clock count of the last closed window |
| err_hold | output | CNT_W (48) | Error count of the last closed window |

## Verification
The bench first runs directed windows. One is valid with lock low and a nonzero error count, which separates the gating of the two accumulators. Another has error counts on clocks without `valid`, which shows the valid qualifier acts on errors too. A single out-of-range error count exposes the clamp, and a window that opens with valid data in the snapshot clock shows where boundary increments land. A long high level on the control bit tells edge detection apart from level detection, and a narrow-width second instance left running past its limit tells saturation apart from wrap-around. Constrained random traffic with occasional snapshots then compares every holding-register value against a bench model.

// File: rtl/ber_pkg.sv
package ber_pkg;
   localparam int unsigned DEF_CNT_W   = 48;
   localparam int unsigned DEF_ERR_W   = 4;
   localparam int unsigned DEF_ERR_MAX = 8;

   function automatic int unsigned inc_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/ber_latch_edge.sv
module ber_latch_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl,
   output logic evt
);
   logic ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= 1'b0;
      else        ctl_q <= ctl;
   end

   assign evt = ctl & ~ctl_q;

   // R7: a held level produces no second event
   assert_single_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/ber_err_gate.sv
module ber_err_gate #(
   parameter int unsigned ERR_W   = ber_pkg::DEF_ERR_W,
   parameter int unsigned ERR_MAX = ber_pkg::DEF_ERR_MAX,
   localparam int unsigned INC_W  = ber_pkg::inc_width(ERR_MAX)
) (
   input  logic             valid,
   input  logic             in_sync,
   input  logic [ERR_W-1:0] err_cnt,
   output logic [INC_W-1:0] inc
);
   localparam int unsigned CMP_W = (ERR_W > INC_W) ? ERR_W : INC_W;
   localparam logic [CMP_W-1:0] MAX_C = CMP_W'(ERR_MAX);

   logic [CMP_W-1:0] err_ext;
   logic [CMP_W-1:0] clamped;

   generate
      if (ERR_MAX >= (2 ** ERR_W)) begin : g_bad_max
         $error("ERR_MAX must be representable in ERR_W bits");
      end
   endgenerate

   always_comb begin
      err_ext = CMP_W'(err_cnt);
      clamped = (err_ext > MAX_C) ? MAX_C : err_ext;
      inc     = (valid && in_sync) ? INC_W'(clamped) : '0;
   end
endmodule

// File: rtl/ber_sat_accum.sv
module ber_sat_accum #(
   parameter int unsigned W     = ber_pkg::DEF_CNT_W,
   parameter int unsigned INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     acc
);
   localparam logic [W:0] MAX_EXT = {1'b0, {W{1'b1}}};

   logic [W:0]   inc_ext;
   logic [W-1:0] nxt;

   assign inc_ext = {{(W + 1 - INC_W){1'b0}}, inc};

   generate
      if (INC_W >= W) begin : g_bad_width
         $error("increment width must be below accumulator width");
      end
      if (INC_W == 1) begin : g_unit
         always_comb begin
            if (clr)       nxt = W'(inc);
            else if (&acc) nxt = acc;
            else           nxt = acc + W'(inc);
         end
      end else begin : g_multi
         logic [W:0] sum_ext;
         always_comb begin
            sum_ext = {1'b0, acc} + inc_ext;
            if (clr)             nxt = W'(inc);
            else if (sum_ext[W]) nxt = {W{1'b1}};
            else                 nxt = sum_ext[W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) acc <= '0;
      else        acc <= nxt;
   end

   // R2 / R3: exact addition below the limit
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ({1'b0, acc} + inc_ext <= MAX_EXT))
      |=> ({1'b0, acc} == $past({1'b0, acc}) + $past(inc_ext)));

   // R6: a full accumulator stays full
   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (&acc)) |=> (&acc));

   // R5: restart keeps only the increment of the snapshot clock
   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ({1'b0, acc} == $past(inc_ext)));
endmodule

// File: rtl/ber_count_latch.sv
module ber_count_latch #(
   parameter int unsigned CNT_W   = ber_pkg::DEF_CNT_W,
   parameter int unsigned ERR_W   = ber_pkg::DEF_ERR_W,
   parameter int unsigned ERR_MAX = ber_pkg::DEF_ERR_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic [ERR_W-1:0] err_cnt,
   input  logic             in_sync,
   input  logic             latch_ctl,
   output logic [CNT_W-1:0] bit_hold,
   output logic [CNT_W-1:0] err_hold
);
   localparam int unsigned INC_W = ber_pkg::inc_width(ERR_MAX);

   logic             snap;
   logic [INC_W-1:0] err_inc;
   logic [CNT_W-1:0] bit_acc;
   logic [CNT_W-1:0] err_acc;

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W too small");
      end
   endgenerate

   ber_latch_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (latch_ctl),
      .evt   (snap)
   );

   ber_err_gate #(.ERR_W(ERR_W), .ERR_MAX(ERR_MAX)) u_gate (
      .valid   (valid),
      .in_sync (in_sync),
      .err_cnt (err_cnt),
      .inc     (err_inc)
   );

   ber_sat_accum #(.W(CNT_W), .INC_W(1)) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (snap),
      .inc   (valid),
      .acc   (bit_acc)
   );

   ber_sat_accum #(.W(CNT_W), .INC_W(INC_W)) u_errs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (snap),
      .inc   (err_inc),
      .acc   (err_acc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_hold <= '0;
         err_hold <= '0;
      end else if (snap) begin
         bit_hold <= bit_acc;
         err_hold <= err_acc;
      end
   end

   // R3: no lock, no error growth
   assert_err_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sync && !snap) |=> $stable(err_acc));

   // R2: bit count ignores lock but needs valid
   assert_bit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !snap) |=> $stable(bit_acc));

   // R4: snapshot takes the pre-edge accumulator values
   assert_hold_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (bit_hold == $past(bit_acc)) && (err_hold == $past(err_acc)));

   // R8: holding registers are quiet between snapshots
   assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(bit_hold) && $stable(err_hold));

   // R9: per-clock error increment never exceeds the limit
   assert_err_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, err_inc} <= (INC_W + 1)'(ERR_MAX)));
endmodule

// File: tb/ber_count_latch_test.sv
module ber_count_latch_test;
   localparam int SW = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, valid, in_sync, latch_ctl;
   logic [3:0]  err_cnt;
   logic [47:0] bit_hold, err_hold;
   logic [SW-1:0] s_bit_hold, s_err_hold;

   int checks = 0;
   int fails  = 0;

   longint m_bacc, m_eacc, m_bh, m_eh;
   longint s_bacc, s_eacc, s_bh, s_eh;
   bit     prev_ctl;

   localparam longint MAXL = 64'h0000_FFFF_FFFF_FFFF;
   localparam longint MAXS = 63;

   ber_count_latch uut (
      .clk(clk), .rst_n(rst_n), .valid(valid), .err_cnt(err_cnt),
      .in_sync(in_sync), .latch_ctl(latch_ctl),
      .bit_hold(bit_hold), .err_hold(err_hold));

   ber_count_latch #(.CNT_W(SW)) uut_small (
      .clk(clk), .rst_n(rst_n), .valid(valid), .err_cnt(err_cnt),
      .in_sync(in_sync), .latch_ctl(latch_ctl),
      .bit_hold(s_bit_hold), .err_hold(s_err_hold));

   function automatic longint sat_add(longint a, longint b, longint mx);
      return (a + b > mx) ? mx : a + b;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      chk({tag, " bit_hold"},   longint'(bit_hold),   m_bh);
      chk({tag, " err_hold"},   longint'(err_hold),   m_eh);
      chk({tag, " s_bit_hold"}, longint'(s_bit_hold), s_bh);
      chk({tag, " s_err_hold"}, longint'(s_err_hold), s_eh);
   endtask

   task automatic step(bit v, int e, bit s, bit l, string tag);
      longint ie;
      bit evt;
      @(negedge clk);
      valid = v; err_cnt = 4'(e); in_sync = s; latch_ctl = l;
      @(posedge clk);
      ie  = (v && s) ? ((e > 8) ? 8 : e) : 0;
      evt = l && !prev_ctl;
      prev_ctl = l;
      if (evt) begin
         m_bh = m_bacc; m_eh = m_eacc; s_bh = s_bacc; s_eh = s_eacc;
         m_bacc = longint'(v); m_eacc = ie; s_bacc = longint'(v); s_eacc = ie;
      end else begin
         m_bacc = sat_add(m_bacc, longint'(v), MAXL);
         m_eacc = sat_add(m_eacc, ie, MAXL);
         s_bacc = sat_add(s_bacc, longint'(v), MAXS);
         s_eacc = sat_add(s_eacc, ie, MAXS);
      end
      #2;
      compare_all(tag);
   endtask

   task automatic snapshot(string tag);
      step(0, 0, 0, 1, tag);
      step(0, 0, 0, 0, tag);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; valid = 1'b0; in_sync = 1'b0; latch_ctl = 1'b0; err_cnt = '0;
      m_bacc = 0; m_eacc = 0; m_bh = 0; m_eh = 0;
      s_bacc = 0; s_eacc = 0; s_bh = 0; s_eh = 0; prev_ctl = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset bit_hold", longint'(bit_hold), 0);
      chk("R1 reset err_hold", longint'(err_hold), 0);
      rst_n = 1'b1;

      // R1: snapshot with nothing counted
      snapshot("R1");
      chk("R1 empty bit", longint'(bit_hold), 0);

      // R2 / R3: valid without lock counts clocks only
      for (int i = 0; i < 10; i++) step(1, 3, 0, 0, "R2");
      snapshot("R2");
      chk("R2 clocks counted", longint'(bit_hold), 10);
      chk("R3 no errors unlocked", longint'(err_hold), 0);

      // R3: errors only with valid and lock
      for (int i = 0; i < 5; i++) step(1, 2, 1, 0, "R3");
      for (int i = 0; i < 3; i++) step(0, 5, 1, 0, "R3");
      snapshot("R3");
      chk("R3 err sum", longint'(err_hold), 10);
      chk("R2 bits with gaps", longint'(bit_hold), 5);

      // R9: out-of-range count clamps
      step(1, 15, 1, 0, "R9");
      snapshot("R9");
      chk("R9 clamp", longint'(err_hold), 8);

      // R5: increments in the snapshot clock go to the new window
      step(1, 1, 1, 0, "R5");
      step(1, 4, 1, 1, "R5");
      chk("R5 old window bit", longint'(bit_hold), 1);
      chk("R5 old window err", longint'(err_hold), 1);
      step(0, 0, 0, 0, "R5");
      snapshot("R5");
      chk("R5 new window bit", longint'(bit_hold), 1);
      chk("R5 new window err", longint'(err_hold), 4);

      // R7 / R8: held level makes one event only
      step(0, 0, 0, 1, "R7");
      for (int i = 0; i < 6; i++) step(1, 1, 1, 1, "R7 R8");
      chk("R8 hold kept", longint'(bit_hold), 0);
      step(1, 1, 1, 0, "R7");
      snapshot("R7");
      chk("R7 no second event", longint'(bit_hold), 7);
      chk("R7 err total", longint'(err_hold), 7);

      // R6: saturation on narrow instance
      for (int i = 0; i < 80; i++) step(1, 8, 1, 0, "R6");
      snapshot("R6");
      chk("R6 small bit sat", longint'(s_bit_hold), 63);
      chk("R6 small err sat", longint'(s_err_hold), 63);
      chk("R6 wide bit", longint'(bit_hold), 80);
      chk("R6 wide err", longint'(err_hold), 640);

      // random traffic, R4 model comparison each clock
      for (int i = 0; i < 3000; i++) begin
         bit v, s, l;
         int e;
         v = ($urandom_range(0, 3) != 0);
         s = ($urandom_range(0, 4) != 0);
         e = $urandom_range(0, 15);
         if (e > 9) e = $urandom_range(0, 2);
         l = ($urandom_range(0, 19) == 0) ? ~prev_ctl : prev_ctl;
         step(v, e, s, l, "R4 R8 random");
      end
      snapshot("R4 final");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule